// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block queues 36-bit words between two unrelated clock domains. A producer pushes words on the write clock, and a consumer takes them on the read clock. Each side sees only flags that are registered in its own domain. The write side sees a space-available flag and an active-low near-full flag. The read side sees a data-available flag and an active-low near-empty flag.

A static mode input selects how the read side behaves:
- **Standard mode.** A read strobe moves the next word into the output register. The word appears there after that clock edge.
- **Look-ahead (first-word-fall-through) mode.** The block preloads the head word into the output register without being asked. The read strobe then acknowledges that word and lets the next one in.

The near-empty offset X and the near-full offset Y load preset values at reset. After that, a small configuration port in the write domain can rewrite them.

The read and write pointers cross between domains as Gray code through two flip-flop stages. Because of this, each flag takes exactly two edges of its own clock to see an event from the other side. The word count used by the near-flags covers memory only. A word already sitting in the output register counts as removed.

Top module: `dcf_fifo`

## Requirements
- R1: After reset, `in_rdy`=1, `out_rdy`=0, `aempty_n`=0, `afull_n`=1. The offsets take X=`AE_PRESET` and Y=`AF_PRESET`.
- R2: `in_rdy` is 1 exactly when the memory count (words in memory, excluding the output register) is below 2^AW. A write strobe while `in_rdy`=0 stores nothing and leaves the write pointer unmoved.
- R3: Each write accepted with `in_rdy`=1 moves the write pointer by one Gray step. Words leave the block in the order in which they were accepted.
- R4: When the memory is full and a read frees a location, `in_rdy` stays 0 after the first write-clock edge that follows the read. It becomes 1 on the second such edge.
- R5: Standard mode (`fwft`=0):
  - `out_rdy` is 1 exactly when the memory count is nonzero.
  - After a write into an empty memory, `out_rdy` stays 0 after the first read-clock edge and becomes 1 on the second.
  - `rd_en` with `out_rdy`=1 places the head word on `rd_data` at that edge.
  - `rd_en` with `out_rdy`=0 changes neither `rd_data` nor the read pointer.
- R6: Look-ahead mode (`fwft`=1):
  - After a write into an empty block, the word appears on `rd_data` and `out_rdy` goes to 1 on the third read-clock edge.
  - The word stays there unchanged until `rd_en` is high at an edge.
  - The block holds up to 2^AW+1 words.
- R7: `aempty_n` is 0 when the memory count is at most X and 1 when it is X+1 or more. A word held in the output register is not counted.
- R8: `afull_n` is 0 when the memory count is at least 2^AW−Y and 1 when it is at most 2^AW−Y−1.
- R9: After the opposite-side event that crosses a near-flag threshold, that flag stays unchanged after the first edge of its own clock. It takes the new value on the second edge.
- R10: A write-clock cycle with `cfg_we`=1 loads `cfg_val` into X when `cfg_sel`=0 and into Y when `cfg_sel`=1. A later reset restores both presets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 36 | Word to store |
| in_rdy | output | 1 | High when a location is free |
| afull_n | output | 1 | Low when the memory count is at least 2^AW−Y |
| cfg_we | input | 1 | Offset load strobe (write domain) |
| cfg_sel | input | 1 | 0 selects X (near-empty), 1 selects Y (near-full) |
| cfg_val | input | AW | Offset value |
| rclk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| fwft | input | 1 | 1 = look-ahead mode, 0 = standard mode; held static |
| rd_en | input | 1 | Read strobe (standard) or acknowledge (look-ahead) |
| rd_data | output | 36 | Output register |
| out_rdy | output | 1 | Standard: memory not empty; look-ahead: output register valid |
| aempty_n | output | 1 | Low when the memory count is at most X |

## Verification
The bench builds the block with AW=4, a 16-word memory, and presets X=2 and Y=3. This small size lets it step through every fill level from empty to full and back in both modes. At each level it compares all four flags and every word drained against a queue model. Reprogramming to X=5 and Y=1 moves both thresholds to different points of the same sweep.

The write and read clocks run with periods of 20 ns and 14 ns and never share an edge. This allows the two-edge and three-edge flag latencies to be counted edge by edge without ambiguity.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  localparam int unsigned WORD_W = 36;

  typedef enum logic {
    OFS_EMPTY = 1'b0,
    OFS_FULL  = 1'b1
  } ofs_sel_e;

  // Gray to binary over a 32-bit container; callers zero-extend and truncate.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
`timescale 1ns/1ps
module dcf_sync2 #(
  parameter int unsigned    W    = 1,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 36
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port doubles as the block's output register.
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side #(
  parameter int unsigned AW        = 4,
  parameter int unsigned AE_PRESET = 2,
  parameter int unsigned AF_PRESET = 3
) (
  input  logic          wclk,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_val,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          in_rdy,
  output logic          afull_n,
  output logic [AW-1:0] ofs_x
);
  import dcf_pkg::*;

  localparam int unsigned PW      = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt, thr;
  logic [AW-1:0] ofs_y;

  assign rbin_s  = PW'(gray_to_bin(32'(rgray_s)));
  assign cnt     = wbin - rbin_s;
  assign thr     = DEPTH_P - {1'b0, ofs_y};
  assign in_rdy  = (cnt != DEPTH_P);
  assign afull_n = (cnt < thr);
  assign we      = wr_en & in_rdy;
  assign waddr   = wbin[AW-1:0];
  assign wbin_nx = wbin + PW'(1);

  always_ff @(posedge wclk) begin
    if (wr_rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_rst) begin
      ofs_x <= AW'(AE_PRESET);
      ofs_y <= AW'(AF_PRESET);
    end else if (cfg_we) begin
      if (ofs_sel_e'(cfg_sel) == OFS_FULL) ofs_y <= cfg_val;
      else                                 ofs_x <= cfg_val;
    end
  end

endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter int unsigned AW = 4
) (
  input  logic          rclk,
  input  logic          rd_rst,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ofs_x_s,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          re,
  output logic          out_rdy,
  output logic          aempty_n
);
  import dcf_pkg::*;

  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nx, wbin_s, mcnt;
  logic          mem_empty;
  logic          held;

  assign wbin_s    = PW'(gray_to_bin(32'(wgray_s)));
  assign mcnt      = wbin_s - rbin;
  assign mem_empty = (mcnt == '0);
  assign re        = ~mem_empty & (fwft ? (~held | rd_en) : rd_en);
  assign out_rdy   = fwft ? held : ~mem_empty;
  assign aempty_n  = (mcnt > {1'b0, ofs_x_s});
  assign raddr     = rbin[AW-1:0];
  assign rbin_nx   = rbin + PW'(1);

  always_ff @(posedge rclk) begin
    if (rd_rst) begin
      rbin  <= '0;
      rgray <= '0;
      held  <= 1'b0;
    end else begin
      if (re) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
      if (!fwft)      held <= 1'b0;
      else if (re)    held <= 1'b1;
      else if (rd_en) held <= 1'b0;
    end
  end

endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo #(
  parameter int unsigned AW        = 4,
  parameter int unsigned DW        = dcf_pkg::WORD_W,
  parameter int unsigned AE_PRESET = 2,
  parameter int unsigned AF_PRESET = 3
) (
  input  logic          wclk,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          in_rdy,
  output logic          afull_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_val,
  input  logic          rclk,
  input  logic          rd_rst,
  input  logic          fwft,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          out_rdy,
  output logic          aempty_n
);

  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr, ofs_x, ofs_x_s;
  logic          we, re;

  dcf_wr_side #(.AW(AW), .AE_PRESET(AE_PRESET), .AF_PRESET(AF_PRESET)) u_wr (
    .wclk(wclk), .wr_rst(wr_rst), .wr_en(wr_en), .rgray_s(rgray_s),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .wgray(wgray), .waddr(waddr), .we(we), .in_rdy(in_rdy),
    .afull_n(afull_n), .ofs_x(ofs_x)
  );

  dcf_sync2 #(.W(AW+1), .INIT('0)) u_r2w (
    .clk(wclk), .rst(wr_rst), .d(rgray), .q(rgray_s)
  );

  dcf_sync2 #(.W(AW+1), .INIT('0)) u_w2r (
    .clk(rclk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );

  // Offset X is quasi-static; reprogram only while the read side is idle.
  dcf_sync2 #(.W(AW), .INIT(AW'(AE_PRESET))) u_ofs (
    .clk(rclk), .rst(rd_rst), .d(ofs_x), .q(ofs_x_s)
  );

  dcf_rd_side #(.AW(AW)) u_rd (
    .rclk(rclk), .rd_rst(rd_rst), .fwft(fwft), .rd_en(rd_en),
    .wgray_s(wgray_s), .ofs_x_s(ofs_x_s), .rgray(rgray), .raddr(raddr),
    .re(re), .out_rdy(out_rdy), .aempty_n(aempty_n)
  );

  dcf_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .re(re), .raddr(raddr), .rdata(rd_data)
  );

endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 36
) (
  input logic          wclk,
  input logic          wr_rst,
  input logic          wr_en,
  input logic          in_rdy,
  input logic [AW:0]   wgray,
  input logic          rclk,
  input logic          rd_rst,
  input logic          fwft,
  input logic          rd_en,
  input logic          out_rdy,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   rgray
);

  AST_FULL_BLOCKS: assert property (@(posedge wclk) disable iff (wr_rst)
    (wr_en && !in_rdy) |=> $stable(wgray)) else $error("blocked write moved pointer"); // R2

  AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (wr_rst)
    (wr_en && in_rdy) |=> ($countones(wgray ^ $past(wgray)) == 1)) else $error("write pointer step"); // R3

  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (wr_rst)
    $countones(wgray ^ $past(wgray)) <= 1) else $error("write pointer not Gray"); // R3

  AST_STD_EMPTY_READ: assert property (@(posedge rclk) disable iff (rd_rst)
    (!fwft && rd_en && !out_rdy) |=> ($stable(rgray) && $stable(rd_data))) else $error("empty read acted"); // R5

  AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (rd_rst)
    $countones(rgray ^ $past(rgray)) <= 1) else $error("read pointer not Gray"); // R5

  AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (rd_rst)
    (fwft && out_rdy && !rd_en) |=> (out_rdy && $stable(rd_data))) else $error("head word not held"); // R6

endmodule

bind dcf_fifo dcf_fifo_chk #(.AW(AW), .DW(DW)) u_dcf_fifo_chk (
  .wclk(wclk), .wr_rst(wr_rst), .wr_en(wr_en), .in_rdy(in_rdy), .wgray(wgray),
  .rclk(rclk), .rd_rst(rd_rst), .fwft(fwft), .rd_en(rd_en), .out_rdy(out_rdy),
  .rd_data(rd_data), .rgray(rgray)
);

// File: tb/dcf_fifo_bench.sv
`timescale 1ns/1ps
module dcf_fifo_bench;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int XP    = 2;
  localparam int YP    = 3;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wr_rst = 1'b1, rd_rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, fwft = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_val = '0;
  logic [35:0] wr_data = '0;
  logic in_rdy, afull_n, out_rdy, aempty_n;
  logic [35:0] rd_data;

  int n_tests = 0, n_fail = 0, seq = 1, cur_x = XP, cur_y = YP;
  logic [35:0] q[$];

  dcf_fifo #(.AW(AW), .AE_PRESET(XP), .AF_PRESET(YP)) u_dcf_fifo (
    .wclk(wclk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .in_rdy(in_rdy), .afull_n(afull_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val), .rclk(rclk), .rd_rst(rd_rst), .fwft(fwft),
    .rd_en(rd_en), .rd_data(rd_data), .out_rdy(out_rdy), .aempty_n(aempty_n)
  );

  // 50 MHz write clock; 14 ns read clock whose edges never meet it.
  always #10 wclk = ~wclk;
  initial begin
    #3;
    forever begin rclk = 1'b1; #7; rclk = 1'b0; #7; end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #0.3;
  endtask

  task automatic do_reset(input logic mode);
    wr_rst = 1'b1; rd_rst = 1'b1; fwft = mode;
    wr_en = 1'b0; rd_en = 1'b0; cfg_we = 1'b0;
    repeat (3) @(posedge wclk);
    repeat (3) @(posedge rclk);
    #0.3;
    wr_rst = 1'b0; rd_rst = 1'b0;
    q.delete(); cur_x = XP; cur_y = YP;
    settle();
  endtask

  task automatic push();
    @(posedge wclk); #0.3;
    wr_data = {4'(seq), 32'(seq * 32'h9E37_79B1)};
    if (in_rdy) q.push_back(wr_data);
    wr_en = 1'b1; seq++;
    @(posedge wclk); #0.3;
    wr_en = 1'b0;
  endtask

  task automatic rd_pulse();
    @(posedge rclk); #0.3; rd_en = 1'b1;
    @(posedge rclk); #0.3; rd_en = 1'b0;
  endtask

  task automatic pop(input string req);
    logic [35:0] e;
    if (fwft) begin
      chk(req, 64'(out_rdy), 64'd1);
      e = q.pop_front();
      chk(req, 64'(rd_data), 64'(e));
      rd_pulse();
    end else begin
      e = q.pop_front();
      rd_pulse();
      chk(req, 64'(rd_data), 64'(e));
    end
  endtask

  task automatic cfg_write(input logic s, input logic [AW-1:0] v);
    @(posedge wclk); #0.3; cfg_we = 1'b1; cfg_sel = s; cfg_val = v;
    @(posedge wclk); #0.3; cfg_we = 1'b0;
  endtask

  task automatic check_levels(input int n);
    int m;
    m = fwft ? ((n > 0) ? n - 1 : 0) : n;
    chk("R2", 64'(in_rdy), 64'(m < DEPTH));
    chk(fwft ? "R6" : "R5", 64'(out_rdy), 64'(n > 0));
    chk("R7", 64'(aempty_n), 64'(m > cur_x));
    chk("R8", 64'(afull_n), 64'(m < DEPTH - cur_y));
  endtask

  task automatic sweep();
    int cap;
    cap = fwft ? DEPTH + 1 : DEPTH;
    for (int n = 0; n <= cap; n++) begin
      check_levels(n);
      if (n < cap) begin push(); settle(); end
    end
    push(); settle();                 // attempt while full: ignored (R2)
    check_levels(cap);
    chk("R2", 64'(q.size()), 64'(cap));
    for (int n = cap; n > 0; n--) begin
      pop("R3"); settle();
      check_levels(n - 1);
    end
  endtask

  initial begin
    logic [35:0] last;
    // R1 reset state, standard mode
    do_reset(1'b0);
    chk("R1", 64'(in_rdy), 64'd1);
    chk("R1", 64'(out_rdy), 64'd0);
    chk("R1", 64'(aempty_n), 64'd0);
    chk("R1", 64'(afull_n), 64'd1);

    // Standard-mode sweep with preset offsets
    sweep();

    // R5: strobe while empty is ignored
    last = rd_data;
    rd_pulse(); settle();
    chk("R5", 64'(rd_data), 64'(last));
    chk("R5", 64'(out_rdy), 64'd0);

    // R5 latency of out_rdy after a write into empty memory
    do_reset(1'b0);
    push();
    @(posedge rclk); #0.3; chk("R5", 64'(out_rdy), 64'd0);
    @(posedge rclk); #0.3; chk("R5", 64'(out_rdy), 64'd1);
    settle();
    // R9 near-empty latency: the 3rd word crosses X=2
    push(); settle();
    push();
    @(posedge rclk); #0.3; chk("R9", 64'(aempty_n), 64'd0);
    @(posedge rclk); #0.3; chk("R9", 64'(aempty_n), 64'd1);
    settle();
    // Fill, then R4 latency of in_rdy after one read
    for (int i = 3; i < DEPTH; i++) push();
    settle();
    chk("R2", 64'(in_rdy), 64'd0);
    pop("R3");
    @(posedge wclk); #0.3; chk("R4", 64'(in_rdy), 64'd0);
    @(posedge wclk); #0.3; chk("R4", 64'(in_rdy), 64'd1);
    settle();
    pop("R3"); pop("R3"); settle();
    chk("R8", 64'(afull_n), 64'd0);   // 13 words, threshold 16-3
    pop("R3");                        // down to 12
    @(posedge wclk); #0.3; chk("R9", 64'(afull_n), 64'd0);
    @(posedge wclk); #0.3; chk("R9", 64'(afull_n), 64'd1);

    // Look-ahead mode
    do_reset(1'b1);
    chk("R1", 64'(in_rdy), 64'd1);
    chk("R1", 64'(out_rdy), 64'd0);
    chk("R1", 64'(aempty_n), 64'd0);
    chk("R1", 64'(afull_n), 64'd1);
    cfg_write(1'b0, AW'(5));
    cfg_write(1'b1, AW'(1));
    cur_x = 5; cur_y = 1;             // R10 programmed offsets
    settle();
    push();
    @(posedge rclk); #0.3; chk("R6", 64'(out_rdy), 64'd0);
    @(posedge rclk); #0.3; chk("R6", 64'(out_rdy), 64'd0);
    @(posedge rclk); #0.3; chk("R6", 64'(out_rdy), 64'd1);
    chk("R6", 64'(rd_data), 64'(q[0]));
    pop("R6"); settle();
    sweep();

    // R10: reset restores presets (X=2, Y=3)
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) push();
    settle();
    chk("R10", 64'(aempty_n), 64'd1);
    for (int i = 3; i < 13; i++) push();
    settle();
    chk("R10", 64'(afull_n), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule